// File: doc/BRIEF.md
# Processor bus cycle capture sampler

This block watches a synchronous 32-bit processor bus and turns each transfer into one compact record for a downstream trace memory or trigger unit. Capture is split across the two clock edges. When the start strobe `ts_n` is sampled low on a rising edge, a cycle opens and its row address and control fields are latched. The column address and data are taken on the falling edge at which a termination strobe is low. A falling-edge register stage holds those values, and the next rising edge folds them into a record. Every record leaves on a rising-edge valid strobe, so all outputs are in one clock domain.

Configuration inputs choose the behaviour. `cfg_dram` selects split row and column capture or single capture at termination. `cfg_alt_incl` keeps or drops cycles that another bus master owns. `cfg_retry_en` lets the retry strobe end a cycle. `cfg_row_mute` suppresses the separate row record.

Each record carries:
- a status code;
- a size class;
- a beat index for burst transfers;
- a flag marking a cycle owned by another master.

Top module: `bus_cycle_sampler`

## Requirements
- R1: With `cfg_dram`=1, a rising edge with `ts_n` low opens a cycle. At the next rising edge the block emits a row record: status 1, `rec_row` holding the address, control and size taken at that edge, and `rec_col` and `rec_data` both zero.
- R2: With `cfg_dram`=1, a falling edge at which `ta_n` is low captures the column address and the data. At the following rising edge a record appears with status 0, those values in `rec_col` and `rec_data`, and `rec_row`, `rec_ttype` and `rec_rnw` taken from the opening edge.
- R3: With `cfg_dram`=0, no row record is emitted. Address, data, transfer type, read/write, size and burst are all taken at the terminating falling edge, and `rec_row` equals `rec_col`.
- R4: Each beat produces exactly one record, and wait-state clocks produce none.
  - A non-burst cycle closes after its first beat; a burst closes after its fourth.
  - `rec_beat` counts 0 to 3 within a cycle and restarts at 0 at each opening edge.
  - A termination strobe with no open cycle is ignored.
- R5: A cycle is owned by another master when `bg_n` is high at its opening edge. With `cfg_alt_incl`=0 such a cycle emits no records. With `cfg_alt_incl`=1 its records carry `rec_alt`=1; all other records carry `rec_alt`=0.
- R6: Termination and its status code:
  - A termination with `tea_n` low closes the cycle with status 2, and `tea_n` takes priority over retry.
  - With `cfg_retry_en`=1, `retry_n` low closes the cycle with status 3.
  - With `cfg_retry_en`=0, `retry_n` is ignored and the cycle stays open.
- R7: `rec_size` is 3 when `burst_n` is low. Otherwise it is 1 for size bits 01, 2 for 10, and 0 for 00 and for 11.
- R8: With `cfg_dram`=1 and `cfg_row_mute`=1, no row record is emitted, but completion records are still emitted.
- R9: Suppose an opening edge arrives while a cycle is open and that cycle has had no beat.
  - An unknown record (status 4) is emitted. It carries the old cycle's opening-edge row address, control and size, with `rec_col`, `rec_data` and `rec_beat` all zero.
  - If the open cycle has had beats, no record is emitted.
  - In both cases the new cycle opens.
- R10: When a completion or unknown record falls on the same edge as a row record, the row record is dropped.
- R11: While `rst_n` is low at a rising edge, `rec_valid` goes low at that edge and any open cycle is discarded. A termination that arrives after reset, for a cycle opened before reset, emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adr_i | input | AW | Address bus |
| dat_i | input | DW | Data bus |
| ttype_i | input | TW | Transfer type bits |
| rnw_i | input | 1 | Read (1) or write (0) |
| tsize_i | input | 2 | Transfer size bits |
| ts_n | input | 1 | Transfer start, active low |
| ta_n | input | 1 | Transfer acknowledge, active low |
| tea_n | input | 1 | Transfer error, active low |
| burst_n | input | 1 | Burst indicator, active low |
| bg_n | input | 1 | Bus grant to this processor, active low |
| retry_n | input | 1 | Retry, active low |
| cfg_dram | input | 1 | 1: split row/column capture |
| cfg_alt_incl | input | 1 | 1: record cycles of other masters |
| cfg_retry_en | input | 1 | 1: retry strobe terminates a cycle |
| cfg_row_mute | input | 1 | 1: suppress row records |
| rec_valid | output | 1 | Record strobe, one clock |
| rec_status | output | 3 | 0 done, 1 row, 2 error, 3 retry, 4 unknown |
| rec_row | output | AW | Row address |
| rec_col | output | AW | Column address |
| rec_data | output | DW | Data |
| rec_ttype | output | TW | Transfer type |
| rec_rnw | output | 1 | Read/write |
| rec_size | output | 2 | Size class |
| rec_beat | output | BW | Beat index |
| rec_alt | output | 1 | Cycle owned by another master |

## Verification
The hardest situations to reach from the ports are those in which two capture paths act on the same rising edge. Two cases matter:
- the falling-edge termination of one cycle arrives just before the rising edge that opens the next;
- a second start strobe arrives into a cycle that has not yet had a beat.

The bench reaches both by asserting the start and acknowledge strobes together in one drive slot, and by sending two start strobes with only a wait clock between them. The same cycle is also swept over every combination of mode, ownership, size and termination kind, so that each field's origin (the opening edge or the terminating edge) is pinned down.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
// Shared codes of the bus cycle sampler: record status values and the
// size-class encoding. Assumes nothing about widths of the bus itself.
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_DONE    = 3'd0,
        ST_ROW     = 3'd1,
        ST_TERR    = 3'd2,
        ST_RETRY   = 3'd3,
        ST_UNKNOWN = 3'd4
    } cyc_status_e;

    localparam logic [1:0] SZ_WORD  = 2'd0;
    localparam logic [1:0] SZ_BYTE  = 2'd1;
    localparam logic [1:0] SZ_HALF  = 2'd2;
    localparam logic [1:0] SZ_BURST = 2'd3;

    // Size class from the active-high burst flag and the two size bits.
    function automatic logic [1:0] size_class(input logic is_burst, input logic [1:0] tsz);
        if (is_burst)          return SZ_BURST;
        else if (tsz == 2'b01) return SZ_BYTE;
        else if (tsz == 2'b10) return SZ_HALF;
        else                   return SZ_WORD;
    endfunction

endpackage

// File: rtl/bcs_fall_capture.sv
`timescale 1ns/1ps
// Falling-edge capture stage. On every falling edge it records whether a
// termination strobe was low and, if so, the address, data and control
// present on the bus. The hit flag lasts exactly one full clock, so the
// next rising edge sees each beat once. Assumes inputs are stable around
// the falling edge.
module bcs_fall_capture #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ta_n,
    input  logic          tea_n,
    input  logic          retry_n,
    input  logic          retry_en,
    input  logic [AW-1:0] adr_i,
    input  logic [DW-1:0] dat_i,
    input  logic [TW-1:0] ttype_i,
    input  logic          rnw_i,
    input  logic [1:0]    tsize_i,
    input  logic          burst_n,
    output logic          hit,
    output logic          f_tea,
    output logic          f_rty,
    output logic [AW-1:0] f_adr,
    output logic [DW-1:0] f_dat,
    output logic [TW-1:0] f_ttype,
    output logic          f_rnw,
    output logic [1:0]    f_tsize,
    output logic          f_burst
);

    logic term_now;

    // A beat ends when acknowledge, error, or an enabled retry is low.
    always_comb term_now = !ta_n || !tea_n || (retry_en && !retry_n);

    // Flags of the falling-edge stage, cleared by reset.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            hit   <= 1'b0;
            f_tea <= 1'b0;
            f_rty <= 1'b0;
        end else begin
            hit   <= term_now;
            f_tea <= !tea_n;
            f_rty <= retry_en && !retry_n;
        end
    end

    // Bus snapshot taken only on a terminating falling edge.
    always_ff @(negedge clk) begin
        if (term_now) begin
            f_adr   <= adr_i;
            f_dat   <= dat_i;
            f_ttype <= ttype_i;
            f_rnw   <= rnw_i;
            f_tsize <= tsize_i;
            f_burst <= !burst_n;
        end
    end

endmodule

// File: rtl/bcs_cycle_track.sv
`timescale 1ns/1ps
// Rising-edge cycle tracker. Opens a cycle on the start strobe, latches
// the opening-edge fields, counts beats, and decides which record event
// (completion, unknown or row) belongs to the current edge. Assumes the
// falling-edge stage presents each beat for exactly one rising edge.
module bcs_cycle_track #(
    parameter int AW    = 32,
    parameter int TW    = 4,
    parameter int BEATS = 4,
    localparam int BW   = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ts_n,
    input  logic [AW-1:0] adr_i,
    input  logic [TW-1:0] ttype_i,
    input  logic          rnw_i,
    input  logic [1:0]    tsize_i,
    input  logic          burst_n,
    input  logic          bg_n,
    input  logic          hit,
    input  logic          f_tea,
    input  logic          f_rty,
    input  logic          f_burst,
    input  logic          cfg_dram,
    input  logic          cfg_row_mute,
    output logic          done_ev,
    output logic          unk_ev,
    output logic          row_ev,
    output logic [BW-1:0] beat,
    output logic          t_alt,
    output logic [AW-1:0] t_adr,
    output logic [TW-1:0] t_ttype,
    output logic          t_rnw,
    output logic [1:0]    t_tsize,
    output logic          t_burst
);

    logic open_q;
    logic seen_q;
    logic burst_eff;
    logic last_beat;
    logic ts_fire;

    // Event decode for this rising edge.
    always_comb begin
        ts_fire   = !ts_n;
        done_ev   = open_q && hit;
        unk_ev    = ts_fire && open_q && !seen_q && !done_ev;
        row_ev    = ts_fire && cfg_dram && !cfg_row_mute && !done_ev && !unk_ev;
        burst_eff = cfg_dram ? t_burst : f_burst;
        last_beat = f_tea || f_rty || !burst_eff || (beat == BW'(BEATS - 1));
    end

    // Cycle state: open flag, beat-seen flag and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            seen_q <= 1'b0;
            beat   <= '0;
        end else if (ts_fire) begin
            open_q <= 1'b1;
            seen_q <= 1'b0;
            beat   <= '0;
        end else if (done_ev) begin
            seen_q <= 1'b1;
            beat   <= beat + 1'b1;
            if (last_beat) open_q <= 1'b0;
        end
    end

    // Opening-edge fields of the current cycle.
    always_ff @(posedge clk) begin
        if (ts_fire) begin
            t_alt   <= bg_n;
            t_adr   <= adr_i;
            t_ttype <= ttype_i;
            t_rnw   <= rnw_i;
            t_tsize <= tsize_i;
            t_burst <= !burst_n;
        end
    end

endmodule

// File: rtl/bcs_record_fmt.sv
`timescale 1ns/1ps
// Record formatter. Picks the single event of this edge (completion over
// unknown over row), assembles its fields from the right capture point,
// applies the other-master filter and registers the record. Assumes the
// tracker never raises unknown together with completion.
module bcs_record_fmt #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TW    = 4,
    parameter int BEATS = 4,
    localparam int BW   = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_dram,
    input  logic          cfg_alt_incl,
    input  logic          done_ev,
    input  logic          unk_ev,
    input  logic          row_ev,
    input  logic [BW-1:0] beat,
    input  logic          t_alt,
    input  logic [AW-1:0] t_adr,
    input  logic [TW-1:0] t_ttype,
    input  logic          t_rnw,
    input  logic [1:0]    t_tsize,
    input  logic          t_burst,
    input  logic          f_tea,
    input  logic          f_rty,
    input  logic [AW-1:0] f_adr,
    input  logic [DW-1:0] f_dat,
    input  logic [TW-1:0] f_ttype,
    input  logic          f_rnw,
    input  logic [1:0]    f_tsize,
    input  logic          f_burst,
    input  logic [AW-1:0] adr_i,
    input  logic [TW-1:0] ttype_i,
    input  logic          rnw_i,
    input  logic [1:0]    tsize_i,
    input  logic          burst_n,
    input  logic          bg_n,
    output logic          rec_valid,
    output logic [2:0]    rec_status,
    output logic [AW-1:0] rec_row,
    output logic [AW-1:0] rec_col,
    output logic [DW-1:0] rec_data,
    output logic [TW-1:0] rec_ttype,
    output logic          rec_rnw,
    output logic [1:0]    rec_size,
    output logic [BW-1:0] rec_beat,
    output logic          rec_alt
);
    import bcs_pkg::*;

    logic          n_alt;
    logic          n_emit;
    cyc_status_e   n_st;
    logic [AW-1:0] n_row;
    logic [AW-1:0] n_col;
    logic [DW-1:0] n_dat;
    logic [TW-1:0] n_tt;
    logic          n_rnw;
    logic [1:0]    n_sz;
    logic [BW-1:0] n_beat;

    // Field selection for the winning event of this edge.
    always_comb begin
        n_alt  = 1'b0;
        n_st   = ST_DONE;
        n_row  = '0;
        n_col  = '0;
        n_dat  = '0;
        n_tt   = '0;
        n_rnw  = 1'b0;
        n_sz   = SZ_WORD;
        n_beat = '0;
        if (done_ev) begin
            n_alt  = t_alt;
            n_row  = cfg_dram ? t_adr : f_adr;
            n_col  = f_adr;
            n_dat  = f_dat;
            n_tt   = cfg_dram ? t_ttype : f_ttype;
            n_rnw  = cfg_dram ? t_rnw : f_rnw;
            n_sz   = cfg_dram ? size_class(t_burst, t_tsize) : size_class(f_burst, f_tsize);
            n_beat = beat;
            n_st   = f_tea ? ST_TERR : (f_rty ? ST_RETRY : ST_DONE);
        end else if (unk_ev) begin
            n_alt = t_alt;
            n_row = t_adr;
            n_tt  = t_ttype;
            n_rnw = t_rnw;
            n_sz  = size_class(t_burst, t_tsize);
            n_st  = ST_UNKNOWN;
        end else if (row_ev) begin
            n_alt = bg_n;
            n_row = adr_i;
            n_tt  = ttype_i;
            n_rnw = rnw_i;
            n_sz  = size_class(!burst_n, tsize_i);
            n_st  = ST_ROW;
        end
        n_emit = (done_ev || unk_ev || row_ev) && (!n_alt || cfg_alt_incl);
    end

    // Record strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rec_valid <= 1'b0;
        else        rec_valid <= n_emit;
    end

    // Record fields, loaded only with an emitted record.
    always_ff @(posedge clk) begin
        if (n_emit) begin
            rec_status <= n_st;
            rec_row    <= n_row;
            rec_col    <= n_col;
            rec_data   <= n_dat;
            rec_ttype  <= n_tt;
            rec_rnw    <= n_rnw;
            rec_size   <= n_sz;
            rec_beat   <= n_beat;
            rec_alt    <= n_alt;
        end
    end

endmodule

// File: rtl/bus_cycle_sampler.sv
`timescale 1ns/1ps
// Top of the bus cycle sampler. A falling-edge stage catches terminating
// beats, a rising-edge tracker follows cycle state, and a formatter emits
// one record per edge at most. Assumes a single bus clock for all strobes.
module bus_cycle_sampler #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TW    = 4,
    parameter int BEATS = 4,
    localparam int BW   = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] adr_i,
    input  logic [DW-1:0] dat_i,
    input  logic [TW-1:0] ttype_i,
    input  logic          rnw_i,
    input  logic [1:0]    tsize_i,
    input  logic          ts_n,
    input  logic          ta_n,
    input  logic          tea_n,
    input  logic          burst_n,
    input  logic          bg_n,
    input  logic          retry_n,
    input  logic          cfg_dram,
    input  logic          cfg_alt_incl,
    input  logic          cfg_retry_en,
    input  logic          cfg_row_mute,
    output logic          rec_valid,
    output logic [2:0]    rec_status,
    output logic [AW-1:0] rec_row,
    output logic [AW-1:0] rec_col,
    output logic [DW-1:0] rec_data,
    output logic [TW-1:0] rec_ttype,
    output logic          rec_rnw,
    output logic [1:0]    rec_size,
    output logic [BW-1:0] rec_beat,
    output logic          rec_alt
);

    logic          hit, f_tea, f_rty, f_rnw, f_burst;
    logic [AW-1:0] f_adr;
    logic [DW-1:0] f_dat;
    logic [TW-1:0] f_ttype;
    logic [1:0]    f_tsize;
    logic          done_ev, unk_ev, row_ev;
    logic [BW-1:0] beat;
    logic          t_alt, t_rnw, t_burst;
    logic [AW-1:0] t_adr;
    logic [TW-1:0] t_ttype;
    logic [1:0]    t_tsize;

    bcs_fall_capture #(.AW(AW), .DW(DW), .TW(TW)) u_fall (
        .clk(clk), .rst_n(rst_n), .ta_n(ta_n), .tea_n(tea_n), .retry_n(retry_n),
        .retry_en(cfg_retry_en), .adr_i(adr_i), .dat_i(dat_i), .ttype_i(ttype_i),
        .rnw_i(rnw_i), .tsize_i(tsize_i), .burst_n(burst_n), .hit(hit),
        .f_tea(f_tea), .f_rty(f_rty), .f_adr(f_adr), .f_dat(f_dat),
        .f_ttype(f_ttype), .f_rnw(f_rnw), .f_tsize(f_tsize), .f_burst(f_burst)
    );

    bcs_cycle_track #(.AW(AW), .TW(TW), .BEATS(BEATS)) u_track (
        .clk(clk), .rst_n(rst_n), .ts_n(ts_n), .adr_i(adr_i), .ttype_i(ttype_i),
        .rnw_i(rnw_i), .tsize_i(tsize_i), .burst_n(burst_n), .bg_n(bg_n),
        .hit(hit), .f_tea(f_tea), .f_rty(f_rty), .f_burst(f_burst),
        .cfg_dram(cfg_dram), .cfg_row_mute(cfg_row_mute), .done_ev(done_ev),
        .unk_ev(unk_ev), .row_ev(row_ev), .beat(beat), .t_alt(t_alt),
        .t_adr(t_adr), .t_ttype(t_ttype), .t_rnw(t_rnw), .t_tsize(t_tsize),
        .t_burst(t_burst)
    );

    bcs_record_fmt #(.AW(AW), .DW(DW), .TW(TW), .BEATS(BEATS)) u_fmt (
        .clk(clk), .rst_n(rst_n), .cfg_dram(cfg_dram), .cfg_alt_incl(cfg_alt_incl),
        .done_ev(done_ev), .unk_ev(unk_ev), .row_ev(row_ev), .beat(beat),
        .t_alt(t_alt), .t_adr(t_adr), .t_ttype(t_ttype), .t_rnw(t_rnw),
        .t_tsize(t_tsize), .t_burst(t_burst), .f_tea(f_tea), .f_rty(f_rty),
        .f_adr(f_adr), .f_dat(f_dat), .f_ttype(f_ttype), .f_rnw(f_rnw),
        .f_tsize(f_tsize), .f_burst(f_burst), .adr_i(adr_i), .ttype_i(ttype_i),
        .rnw_i(rnw_i), .tsize_i(tsize_i), .burst_n(burst_n), .bg_n(bg_n),
        .rec_valid(rec_valid), .rec_status(rec_status), .rec_row(rec_row),
        .rec_col(rec_col), .rec_data(rec_data), .rec_ttype(rec_ttype),
        .rec_rnw(rec_rnw), .rec_size(rec_size), .rec_beat(rec_beat),
        .rec_alt(rec_alt)
    );

endmodule

// File: rtl/bus_cycle_sampler_chk.sv
`timescale 1ns/1ps
// Property checker for the bus cycle sampler, bound to the top module.
// Relates the record outputs to the strobes and options one edge earlier.
module bus_cycle_sampler_chk #(
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ts_n,
    input logic          cfg_dram,
    input logic          cfg_alt_incl,
    input logic          cfg_retry_en,
    input logic          cfg_row_mute,
    input logic          rec_valid,
    input logic [2:0]    rec_status,
    input logic [1:0]    rec_size,
    input logic [BW-1:0] rec_beat,
    input logic          rec_alt
);

    // R1: a row record always follows an edge with the start strobe low.
    a_r1_row_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_status == 3'd1) |-> $past(!ts_n));

    // R8: a row record needs DRAM mode with row records unmuted.
    a_r8_row_needs_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_status == 3'd1) |-> $past(cfg_dram && !cfg_row_mute));

    // R4: a non-burst record never reports a beat other than zero.
    a_r4_single_beat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_size != 2'd3) |-> (rec_beat == '0));

    // R5: records of another master only when they are included.
    a_r5_alt_included: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_alt) |-> $past(cfg_alt_incl));

    // R6: retry status only when the retry option was on.
    a_r6_retry_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_status == 3'd3) |-> $past(cfg_retry_en));

    // R9: unknown status only on an edge with the start strobe low.
    a_r9_unknown_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_status == 3'd4) |-> $past(!ts_n));

    // R11: no record on the first edge after reset is released.
    a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $past(rst_n));

endmodule

bind bus_cycle_sampler bus_cycle_sampler_chk #(.BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ts_n(ts_n), .cfg_dram(cfg_dram),
    .cfg_alt_incl(cfg_alt_incl), .cfg_retry_en(cfg_retry_en),
    .cfg_row_mute(cfg_row_mute), .rec_valid(rec_valid), .rec_status(rec_status),
    .rec_size(rec_size), .rec_beat(rec_beat), .rec_alt(rec_alt)
);

// File: tb/sim_bus_cycle_sampler.sv
`timescale 1ns/1ps
module sim_bus_cycle_sampler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] adr_i = '0;
    logic [31:0] dat_i = '0;
    logic [3:0]  ttype_i = '0;
    logic        rnw_i = 1'b0;
    logic [1:0]  tsize_i = '0;
    logic        ts_n = 1'b1, ta_n = 1'b1, tea_n = 1'b1, burst_n = 1'b1;
    logic        bg_n = 1'b0, retry_n = 1'b1;
    logic        cfg_dram = 1'b1, cfg_alt_incl = 1'b0, cfg_retry_en = 1'b0, cfg_row_mute = 1'b0;
    logic        rec_valid;
    logic [2:0]  rec_status;
    logic [31:0] rec_row, rec_col, rec_data;
    logic [3:0]  rec_ttype;
    logic        rec_rnw;
    logic [1:0]  rec_size;
    logic [1:0]  rec_beat;
    logic        rec_alt;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    bus_cycle_sampler u0 (
        .clk(clk), .rst_n(rst_n), .adr_i(adr_i), .dat_i(dat_i), .ttype_i(ttype_i),
        .rnw_i(rnw_i), .tsize_i(tsize_i), .ts_n(ts_n), .ta_n(ta_n), .tea_n(tea_n),
        .burst_n(burst_n), .bg_n(bg_n), .retry_n(retry_n), .cfg_dram(cfg_dram),
        .cfg_alt_incl(cfg_alt_incl), .cfg_retry_en(cfg_retry_en),
        .cfg_row_mute(cfg_row_mute), .rec_valid(rec_valid), .rec_status(rec_status),
        .rec_row(rec_row), .rec_col(rec_col), .rec_data(rec_data),
        .rec_ttype(rec_ttype), .rec_rnw(rec_rnw), .rec_size(rec_size),
        .rec_beat(rec_beat), .rec_alt(rec_alt)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: rising edge, then settle; inputs change after this.
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic bus_idle();
        ts_n = 1'b1; ta_n = 1'b1; tea_n = 1'b1; retry_n = 1'b1;
    endtask

    task automatic exp_none(input string req);
        check(req, 64'(rec_valid), 64'd0);
    endtask

    task automatic exp_rec(input string req, input int st, input logic [31:0] row,
                           input logic [31:0] col, input logic [31:0] dat,
                           input logic [3:0] tt, input logic rnw, input int sz,
                           input int beat, input logic alt);
        check({req, " valid"}, 64'(rec_valid), 64'd1);
        if (rec_valid) begin
            check({req, " status"}, 64'(rec_status), 64'(st));
            check({req, " row"}, 64'(rec_row), 64'(row));
            check({req, " col"}, 64'(rec_col), 64'(col));
            check({req, " data"}, 64'(rec_data), 64'(dat));
            check({req, " ttype"}, 64'(rec_ttype), 64'(tt));
            check({req, " rnw"}, 64'(rec_rnw), 64'(rnw));
            check("R7 size", 64'(rec_size), 64'(sz));
            check("R4 beat", 64'(rec_beat), 64'(beat));
            check("R5 alt", 64'(rec_alt), 64'(alt));
        end
    endtask

    // term: 0 acknowledge, 1 error, 2 enabled retry, 3 disabled retry.
    task automatic run_cycle(input int id, input bit dram, input bit incl, input bit mute,
                             input bit alt, input int s, input int term);
        logic [31:0] a = 32'h4000_0000 + 32'(id) * 32'h100;
        logic [3:0]  t1 = 4'(id);
        logic        rw = id[0];
        bit          brst = (s == 3);
        int          sz = s;
        bit          vis = !alt || incl;
        int          nb = brst ? 4 : 1;
        int          lastb = brst ? 2 : 0;
        string       lab = dram ? "R2" : "R3";
        cfg_dram = dram; cfg_alt_incl = incl; cfg_row_mute = mute;
        cfg_retry_en = (term == 2);
        bus_idle();
        tick();
        exp_none("R4 idle");
        ts_n = 1'b0; adr_i = a; ttype_i = t1; rnw_i = rw;
        tsize_i = (s == 1) ? 2'b01 : ((s == 2) ? 2'b10 : 2'b00);
        burst_n = !brst; bg_n = alt;
        tick();
        if (dram && !mute && vis) exp_rec("R1", 1, a, 0, 0, t1, rw, sz, 0, alt);
        else if (!vis) exp_none("R5 row excluded");
        else if (!dram) exp_none("R3 no row record");
        else exp_none("R8 row muted");
        ts_n = 1'b1; adr_i = ~a; ttype_i = ~t1; rnw_i = !rw;
        tick();
        exp_none("R4 wait after start");
        for (int b = 0; b < nb; b++) begin
            logic [31:0] cv = a + 32'h1000 + 32'(b) * 4;
            logic [31:0] dv = {16'(id), 16'(b)} ^ 32'h5A5A_0000;
            int st = 0;
            if (term == 3 && b == lastb) begin
                retry_n = 1'b0; adr_i = cv;
                tick();
                exp_none("R6 retry ignored");
                retry_n = 1'b1;
            end
            adr_i = cv; dat_i = dv;
            if (b == lastb && term == 1) begin tea_n = 1'b0; st = 2; end
            else if (b == lastb && term == 2) begin retry_n = 1'b0; st = 3; end
            else ta_n = 1'b0;
            tick();
            if (vis) exp_rec(lab, st, dram ? a : cv, cv, dv, dram ? t1 : ~t1,
                             dram ? rw : !rw, sz, b, alt);
            else exp_none("R5 beat excluded");
            bus_idle(); adr_i = ~cv;
            tick();
            exp_none("R4 wait between beats");
            if (st != 0) break;
        end
        ta_n = 1'b0;
        tick();
        exp_none("R11 acknowledge with no open cycle");
        bus_idle();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int id = 1;
        repeat (3) tick();
        exp_none("R11 reset state");
        rst_n = 1'b1;
        tick();
        exp_none("R11 idle after reset");

        for (int d = 0; d < 2; d++)
            for (int ic = 0; ic < 2; ic++)
                for (int m = 0; m < 2; m++)
                    for (int al = 0; al < 2; al++)
                        for (int s = 0; s < 4; s++)
                            for (int t = 0; t < 4; t++) begin
                                run_cycle(id, d[0], ic[0], m[0], al[0], s, t);
                                id++;
                            end

        // R9: second start with no beat gives an unknown record.
        cfg_dram = 1; cfg_alt_incl = 1; cfg_row_mute = 0; cfg_retry_en = 0; bg_n = 0;
        burst_n = 1; tsize_i = 2'b10;
        ts_n = 0; adr_i = 32'h1111_0000; ttype_i = 4'h3; rnw_i = 1;
        tick();
        exp_rec("R1", 1, 32'h1111_0000, 0, 0, 4'h3, 1, 2, 0, 0);
        ts_n = 1; tick();
        exp_none("R4 wait");
        ts_n = 0; adr_i = 32'h2222_0000; ttype_i = 4'h6; rnw_i = 0; tsize_i = 2'b01;
        tick();
        exp_rec("R9 R10 unknown", 4, 32'h1111_0000, 0, 0, 4'h3, 1, 2, 0, 0);
        ts_n = 1; tick();
        exp_none("R4 wait");
        ta_n = 0; adr_i = 32'h2222_0040; dat_i = 32'hCAFE_0001;
        tick();
        exp_rec("R9 new cycle", 0, 32'h2222_0000, 32'h2222_0040, 32'hCAFE_0001, 4'h6, 0, 1, 0, 0);
        bus_idle(); tick();

        // R9: a start after a burst beat gives no unknown; beat restarts (R4).
        ts_n = 0; burst_n = 0; tsize_i = 2'b00; adr_i = 32'h3300_0000; ttype_i = 4'h9;
        tick();
        exp_rec("R1", 1, 32'h3300_0000, 0, 0, 4'h9, 0, 3, 0, 0);
        ts_n = 1; tick();
        ta_n = 0; adr_i = 32'h3300_0100; dat_i = 32'h0000_00B0;
        tick();
        exp_rec("R2", 0, 32'h3300_0000, 32'h3300_0100, 32'h0000_00B0, 4'h9, 0, 3, 0, 0);
        ta_n = 1; ts_n = 0; burst_n = 1; tsize_i = 2'b00; adr_i = 32'h4400_0000; ttype_i = 4'h2;
        tick();
        exp_rec("R9 no unknown after beat", 1, 32'h4400_0000, 0, 0, 4'h2, 0, 0, 0, 0);
        ts_n = 1; tick();
        ta_n = 0; adr_i = 32'h4400_0010; dat_i = 32'h0000_00C0;
        tick();
        exp_rec("R4 beat restart", 0, 32'h4400_0000, 32'h4400_0010, 32'h0000_00C0, 4'h2, 0, 0, 0, 0);
        bus_idle(); tick();

        // R10: completion and next start on the same edge drop the row record.
        ts_n = 0; adr_i = 32'h5500_0000; ttype_i = 4'h1;
        tick();
        exp_rec("R1", 1, 32'h5500_0000, 0, 0, 4'h1, 0, 0, 0, 0);
        ts_n = 1; tick();
        ts_n = 0; ta_n = 0; adr_i = 32'h6600_0000; ttype_i = 4'h7; dat_i = 32'h0000_0D00;
        tick();
        exp_rec("R10 completion wins", 0, 32'h5500_0000, 32'h6600_0000, 32'h0000_0D00, 4'h1, 0, 0, 0, 0);
        bus_idle(); tick();
        exp_none("R10 row record dropped");
        ta_n = 0; adr_i = 32'h6600_0020; dat_i = 32'h0000_0E00;
        tick();
        exp_rec("R10 next cycle open", 0, 32'h6600_0000, 32'h6600_0020, 32'h0000_0E00, 4'h7, 0, 0, 0, 0);
        bus_idle(); tick();

        // R6: error and retry together give error status.
        cfg_retry_en = 1; cfg_row_mute = 1;
        ts_n = 0; adr_i = 32'h7700_0000; ttype_i = 4'h4;
        tick();
        exp_none("R8 row muted");
        ts_n = 1; tick();
        tea_n = 0; retry_n = 0; adr_i = 32'h7700_0004; dat_i = 32'h0000_0F00;
        tick();
        exp_rec("R6 error over retry", 2, 32'h7700_0000, 32'h7700_0004, 32'h0000_0F00, 4'h4, 0, 0, 0, 0);
        bus_idle(); tick();

        // R7: size bits 11 report the word class.
        cfg_retry_en = 0;
        ts_n = 0; tsize_i = 2'b11; adr_i = 32'h8800_0000; ttype_i = 4'h5;
        tick();
        ts_n = 1; tick();
        ta_n = 0; adr_i = 32'h8800_0008; dat_i = 32'h0000_0A00;
        tick();
        exp_rec("R7 size 11", 0, 32'h8800_0000, 32'h8800_0008, 32'h0000_0A00, 4'h5, 0, 0, 0, 0);
        bus_idle(); tick();

        // R11: reset in the middle of a cycle discards it.
        ts_n = 0; adr_i = 32'h9900_0000;
        tick();
        ts_n = 1; rst_n = 0;
        tick();
        exp_none("R11 valid low in reset");
        rst_n = 1;
        tick();
        ta_n = 0; adr_i = 32'h9900_0004;
        tick();
        exp_none("R11 no record for reset cycle");
        bus_idle(); tick();

        summary();
        $finish;
    end

endmodule